// File: doc/BRIEF.md
# Token Queue to Periodic Sample Adapter

This block joins a producer that hands over data tokens whenever it has them to a consumer that reads one held value at a fixed pace. Tokens enter through a valid/ready write port and wait in a small internal queue. A programmable pacing counter marks sample instants. At each instant the block removes the oldest token and loads its value into an output register. The register keeps that value until the next instant, so downstream logic may read it as often as it wants.

A sample instant that finds the queue empty is an underflow. The output then keeps its last value, a one-cycle underflow pulse is raised, and a sticky error bit is set. The error bit stays set until reset or a clear request. A full queue drops the write-side ready, so no token is ever lost. The output-valid bit stays low until the first token has been delivered.

Top module: `tok_rate_adapter`

## Requirements
- R1: After reset, out_valid_o, out_data_o, smp_stb_o, uflow_o and err_o are all 0 and in_ready_o is 1.
- R2: A token is accepted on every clock edge with in_valid_i and in_ready_o both high. in_ready_o is low exactly when the queue holds DEPTH tokens. Accepted tokens are delivered once each, in arrival order, and none is dropped.
- R3: With period_i = P (P = 0 acts as 1), smp_stb_o is a one-cycle pulse that repeats every P cycles. The first pulse appears P cycles after reset is released.
- R4: At a sample instant with a non-empty queue, exactly one token (the oldest) is removed. Its value is on out_data_o in the same cycle that smp_stb_o is high.
- R5: Between sample instants, out_data_o does not change, whatever happens on the write port.
- R6: At a sample instant with an empty queue, uflow_o pulses together with smp_stb_o and out_data_o and out_valid_o keep their values. A token written on that same edge does not prevent the underflow; it is queued for a later instant.
- R7: err_o becomes 1 with the first underflow and stays 1 until clr_err_i is sampled high. If a clear and an underflow happen on the same edge, err_o is 1 afterwards.
- R8: out_valid_o is 0 until the first token is delivered and 1 from then on.
- R9: A new period_i takes effect at once. If the cycles already counted in the current interval reach the new period, the sample instant fires on the next edge and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Sample period in cycles (0 treated as 1) |
| in_valid_i | input | 1 | Write request |
| in_data_i | input | DW | Write token value |
| in_ready_o | output | 1 | Queue can accept a token |
| clr_err_i | input | 1 | Clears the sticky underflow bit |
| out_data_o | output | DW | Held sample value |
| out_valid_o | output | 1 | A sample has been delivered since reset |
| smp_stb_o | output | 1 | One-cycle pulse at each sample instant |
| uflow_o | output | 1 | One-cycle pulse at a sample instant that found the queue empty |
| err_o | output | 1 | Sticky underflow indication |

## Verification
Assertions check several properties on every cycle. The queue occupancy never exceeds DEPTH, and a pop never happens when the queue is empty. The held output changes only with a strobe, and an underflow leaves it untouched and always sets the error bit. Once the output-valid bit is high it never drops. Only the bench's scenarios can show the rest: arrival order and loss-freedom through full-queue backpressure, the exact strobe spacing for several periods including 0 and 1, the underflow when a write coincides with an instant, the clear-versus-set priority, and the immediate effect of shrinking the period.

// File: rtl/tra_pkg.sv
package tra_pkg;

  // Period value actually used: a zero setting behaves like one cycle.
  function automatic logic [31:0] eff_period(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

endpackage

// File: rtl/tra_queue.sv
module tra_queue #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = wr_q + 1'b1;
    if (do_pop)  rd_d = rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage has no reset; each word is written only under its enable.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // R2: occupancy can never pass the queue depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));

  // R4: a removal request only arrives while tokens are stored
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/tra_pacer.sv
module tra_pacer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  import tra_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   eff;
  logic [CNT_W:0]   nxt_count;

  always_comb begin
    eff       = (CNT_W+1)'(eff_period(32'(period)));
    nxt_count = {1'b0, cnt_q} + 1'b1;
    // Compare with >= so that a shortened period fires right away.
    tick      = (nxt_count >= eff);
    cnt_d     = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: with a steady period the count stays inside the interval
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(period) |-> ({1'b0, cnt_q} < eff) || $changed(period));

endmodule

// File: rtl/tra_hold.sv
module tra_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  input  logic          clr_err,
  output logic          pop,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          stb_o,
  output logic          uf_o,
  output logic          err_o
);
  logic [DW-1:0] data_d;
  logic          valid_d, uf_d, err_d;

  always_comb begin
    pop     = tick && !q_empty;
    uf_d    = tick && q_empty;
    data_d  = pop ? q_head : data_o;
    valid_d = valid_o || pop;
    if (uf_d)         err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
    else              err_d = err_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      stb_o   <= 1'b0;
      uf_o    <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      data_o  <= data_d;
      valid_o <= valid_d;
      stb_o   <= tick;
      uf_o    <= uf_d;
      err_o   <= err_d;
    end
  end

  // R5: held value moves only at a sample instant
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_o |-> $stable(data_o));

  // R6: an underflow instant leaves the held value untouched
  a_r6_keep_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |-> $stable(data_o) && smp_seen(stb_o));

  // R7: every underflow leaves the sticky bit set
  a_r7_err_follows_uf: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |-> err_o);

  // R8: once valid, always valid
  a_r8_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  function automatic logic smp_seen(input logic s);
    return s;
  endfunction

endmodule

// File: rtl/tok_rate_adapter.sv
module tok_rate_adapter #(
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             in_ready_o,
  input  logic             clr_err_i,
  output logic [DW-1:0]    out_data_o,
  output logic             out_valid_o,
  output logic             smp_stb_o,
  output logic             uflow_o,
  output logic             err_o
);
  logic          tick, pop, q_empty, q_full;
  logic [DW-1:0] q_head;

  assign in_ready_o = !q_full;

  tra_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period_i),
    .tick   (tick)
  );

  tra_queue #(.DW(DW), .AW(AW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid_i),
    .push_data (in_data_i),
    .pop       (pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  tra_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .q_empty (q_empty),
    .q_head  (q_head),
    .clr_err (clr_err_i),
    .pop     (pop),
    .data_o  (out_data_o),
    .valid_o (out_valid_o),
    .stb_o   (smp_stb_o),
    .uf_o    (uflow_o),
    .err_o   (err_o)
  );

  // R6: an underflow pulse only accompanies a sample strobe
  a_r6_uf_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |-> smp_stb_o);

endmodule

// File: tb/tb_tok_rate_adapter.sv
`timescale 1ns/1ps
module tb_tok_rate_adapter;
  localparam int DW = 16, AW = 3, CNT_W = 16, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] period_i = 16'd4;
  logic in_valid_i = 0, clr_err_i = 0;
  logic [DW-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, smp_stb_o, uflow_o, err_o;
  logic [DW-1:0] out_data_o;

  always #4 clk = ~clk;

  tok_rate_adapter #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .clr_err_i(clr_err_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .smp_stb_o(smp_stb_o),
    .uflow_o(uflow_o), .err_o(err_o));

  int total = 0, bad = 0;
  bit finished = 0;
  string stb_tag = "R3";

  // Behavioural reference
  int q[$];
  int m_cnt = 0, m_data = 0;
  bit m_valid = 0, m_stb = 0, m_uf = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_data = 0;
      m_valid = 0; m_stb = 0; m_uf = 0; m_err = 0;
    end else begin
      int eff;
      bit tick, push;
      eff  = (period_i == 0) ? 1 : int'(period_i);
      tick = (m_cnt + 1 >= eff);
      push = in_valid_i && (q.size() < DEPTH);
      m_stb = tick;
      m_uf  = 0;
      if (tick) begin
        if (q.size() > 0) begin
          m_data = q.pop_front();
          m_valid = 1;
        end else begin
          m_uf = 1;
        end
      end
      if (m_uf) m_err = 1;
      else if (clr_err_i) m_err = 0;
      if (push) q.push_back(int'(in_data_i));
      m_cnt = tick ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(in_ready_o == (q.size() < DEPTH), "R2 ready", in_ready_o, q.size() < DEPTH);
    chk(int'(out_data_o) == m_data, "R4 R5 data", out_data_o, m_data);
    chk(out_valid_o == m_valid, "R8 valid", out_valid_o, m_valid);
    chk(smp_stb_o == m_stb, stb_tag, smp_stb_o, m_stb);
    chk(uflow_o == m_uf, "R6 underflow", uflow_o, m_uf);
    chk(err_o == m_err, "R7 err", err_o, m_err);
  endtask

  int seq = 16'h1000;

  // one cycle: compare outputs settled after the last edge, then drive
  task automatic cyc(input bit v, input bit clr);
    @(negedge clk);
    compare_all();
    in_valid_i = v;
    in_data_i  = DW'(seq);
    if (v) seq = seq + 16'h0133;
    clr_err_i  = clr;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid_o == 0, "R1 valid", out_valid_o, 0);
    chk(out_data_o == 0, "R1 data", out_data_o, 0);
    chk(smp_stb_o == 0, "R1 stb", smp_stb_o, 0);
    chk(uflow_o == 0, "R1 uflow", uflow_o, 0);
    chk(err_o == 0, "R1 err", err_o, 0);
    chk(in_ready_o == 1, "R1 ready", in_ready_o, 1);

    // idle: first instants underflow (R6, R7), R8 still low
    for (int i = 0; i < 10; i++) cyc(0, 0);
    // sparse writes at period 4 (R4, R5)
    for (int i = 0; i < 40; i++) cyc(i % 3 == 0, 0);
    // clear the sticky bit (R7)
    cyc(0, 1); cyc(0, 0);
    // fill to full with a long period: backpressure (R2)
    period_i = 16'd20;
    for (int i = 0; i < 60; i++) cyc(1, 0);
    // drain until underflow, then clear on an underflow edge (R7 priority)
    period_i = 16'd2;
    for (int i = 0; i < 30; i++) cyc(0, i >= 20);
    // write on the very edge of an instant with empty queue (R6)
    period_i = 16'd3;
    for (int i = 0; i < 24; i++) cyc(i % 3 == 2, 0);
    // period 1 and period 0 streaming (R3)
    period_i = 16'd1;
    for (int i = 0; i < 20; i++) cyc(1, 0);
    period_i = 16'd0;
    for (int i = 0; i < 20; i++) cyc(i % 2 == 0, 0);
    // shrink the period mid-interval (R9)
    period_i = 16'd12;
    for (int i = 0; i < 16; i++) cyc(1, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0);
    stb_tag = "R9";
    period_i = 16'd3;
    for (int i = 0; i < 12; i++) cyc(i % 2 == 0, 0);
    stb_tag = "R3";
    // mixed pattern
    period_i = 16'd5;
    for (int i = 0; i < 80; i++) cyc(((i * 7) % 5) < 2, (i % 17) == 0);
    cyc(0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule